// File: doc/BRIEF.md
# Flash Data Port Access Sequencer

This block lets a host reach an 8-bit external Flash or EPROM one byte at a time. It does this through a small register-style interface. The host loads a 16-bit address, then issues reads or writes to a data port. The block runs the external bus cycle on its own. First it puts the upper address byte on the shared data lines and pulses an address strobe so that an external latch captures it. Next it puts the low byte on dedicated low-address lines. Finally it drives chip-select together with output-enable (for a read) or write-enable (for a write). A 4-bit wait count, applied per access, sets how long that phase lasts.

The host is never stalled. A read of a byte that is not yet held answers with a retry and starts the fetch in the background. A later read returns the byte once it has been captured. A write is posted: it is accepted immediately and carried out in the background. Only a write that collides with a write still in progress is told to retry. When auto-increment is enabled, the low address byte advances after each completed data transfer. It wraps without any carry into the upper byte, so a run of sequential reads needs no further address loads.

Top module: `flash_port_seq`

## Requirements
- R1: During and after reset, chip-select, output-enable and write-enable are high (inactive), the address strobe and data drive-enable are low, and no host response is given.
- R2: Every external access starts with exactly one strobe cycle. In that cycle the upper address byte is on `xd_out` with `xd_oe` high. Chip-select goes low in the cycle that follows. `xa_lo` carries the low address byte and does not change while chip-select is low.
- R3: For a read with wait count W, chip-select and output-enable are both low for exactly W+1 consecutive cycles. `xd_in` is captured at the clock edge that ends the last of these cycles, and write-enable stays high throughout.
- R4: A read of the data port when no valid byte is held answers with a retry (with `resp_rdata` = 0) and starts a fetch. Reads during the fetch also retry. The first read after the fetch completes returns the fetched byte with no retry.
- R5: For a write with wait count W, chip-select and write-enable are both low for max(W,1) consecutive cycles. Output-enable stays high, and the posted byte is driven on `xd_out` with `xd_oe` high.
- R6: A write is accepted with no retry unless an earlier write is still pending or running. In that case the write answers with a retry and is dropped: no bus cycle is made for it.
- R7: With `cfg_autoinc` = 1, the low address byte increments after each read that returns data and after each completed write. With `cfg_autoinc` = 0 it does not change, and repeated reads return the held byte without a new bus cycle.
- R8: The low address byte wraps from 0xFF to 0x00 and leaves the upper byte unchanged.
- R9: Loading the address or accepting a write discards the held byte, so the next read retries and refetches.
- R10: An address load while an access is pending or running answers with a retry and leaves the address unchanged. When idle, it is accepted with no retry.
- R11: A write accepted while a read fetch is running is performed after that read. The fetched byte is discarded.
- R12: Every host request (`host_rd`, `host_wr` or `host_addr_ld`) gets exactly one `resp_valid` pulse in the next cycle, and no response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wait | input | 4 | Access wait count W |
| cfg_autoinc | input | 1 | Enable auto-increment of the low address byte |
| host_addr_ld | input | 1 | Request: load the address |
| host_addr | input | 16 | Address to load {upper, low} |
| host_rd | input | 1 | Request: read the data port |
| host_wr | input | 1 | Request: write the data port |
| host_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | Response pulse, one cycle after a request |
| resp_retry | output | 1 | Response is a retry |
| resp_rdata | output | 8 | Read byte (0 on retry or non-read) |
| xd_out | output | 8 | Shared data/upper-address lines, outgoing |
| xd_oe | output | 1 | Drive enable for `xd_out` |
| xd_in | input | 8 | Shared data lines, incoming |
| xa_lo | output | 8 | Low address lines |
| xstrobe | output | 1 | Upper-address latch strobe, active high |
| xcs_n | output | 1 | Chip-select, active low |
| xoe_n | output | 1 | Output-enable, active low |
| xwe_n | output | 1 | Write-enable, active low |

## Verification
The assertions assume that the host raises at most one of `host_rd`, `host_wr` and `host_addr_ld` in any cycle, and that each request lasts exactly one cycle. The bench meets this because every request comes from a single task that raises one request line for one cycle and lowers it before the next. The assertions also assume that `cfg_wait` and `cfg_autoinc` are changed only while the bus is idle. The bench changes them only after a wait long enough to cover the longest possible access.

// File: rtl/fport_pkg.sv
// Package: types shared by the flash data port sequencer.
// Assumes nothing beyond the standard language.
package fport_pkg;

    // Phases of one external bus access.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_ACCESS = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fport_addr.sv
// Module: address register holding an upper and a low byte.
// The low byte can increment on its own and wraps with no carry.
// Assumes that load and inc are never high in the same cycle; if they are, load wins.
module fport_addr #(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    localparam int ADDR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [HI_W-1:0]   addr_hi,
    output logic [LO_W-1:0]   addr_lo
);

    // Load the full address, or step the low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi <= '0;
            addr_lo <= '0;
        end else if (load) begin
            {addr_hi, addr_lo} <= load_val;
        end else if (inc) begin
            addr_lo <= addr_lo + LO_W'(1);
        end
    end

endmodule

// File: rtl/fport_seq.sv
// Module: external bus timing for one single-byte access.
// The sequence is: one strobe cycle with the upper address on the data lines,
// then an access phase with chip-select low. A read holds the phase for W+1
// cycles and captures data at its last edge. A write holds it for max(W,1) cycles.
// Assumes that start comes only while busy is low, and that wait_cnt is steady during the strobe cycle.
module fport_seq
    import fport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [WAIT_W-1:0] wait_cnt,
    input  logic [DATA_W-1:0] addr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] xd_in,
    output logic              busy,
    output logic              op_wr,
    output logic              done,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] xd_out,
    output logic              xd_oe,
    output logic              xstrobe,
    output logic              xcs_n,
    output logic              xoe_n,
    output logic              xwe_n
);

    seq_state_t        state;
    logic [WAIT_W-1:0] cnt;
    logic              in_acc;

    assign in_acc = (state == SEQ_ACCESS);
    assign done   = in_acc && (cnt == '0);
    assign busy   = (state != SEQ_IDLE);

    // Step through the phases, load the access length and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            op_wr   <= 1'b0;
            cnt     <= '0;
            rd_byte <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_STROBE;
                        op_wr <= start_wr;
                    end
                end
                SEQ_STROBE: begin
                    state <= SEQ_ACCESS;
                    cnt   <= (op_wr && wait_cnt != '0) ? wait_cnt - WAIT_W'(1) : wait_cnt;
                end
                SEQ_ACCESS: begin
                    if (cnt == '0) begin
                        state <= SEQ_IDLE;
                        if (!op_wr) rd_byte <= xd_in;
                    end else begin
                        cnt <= cnt - WAIT_W'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Decode the bus pins from the phase.
    always_comb begin
        xstrobe = (state == SEQ_STROBE);
        xcs_n   = !in_acc;
        xoe_n   = !(in_acc && !op_wr);
        xwe_n   = !(in_acc && op_wr);
        xd_oe   = xstrobe || (in_acc && op_wr);
        if (xstrobe)               xd_out = addr_hi;
        else if (in_acc && op_wr)  xd_out = wr_data;
        else                       xd_out = '0;
    end

endmodule

// File: rtl/fport_host.sv
// Module: host-side handshake. It decides, per request, between an answer and a retry.
// It holds the fetched-byte valid flag and the posted write buffer, and it launches bus accesses.
// Assumes at most one request per cycle.
module fport_host #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_addr_ld,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              cfg_autoinc,
    input  logic              seq_busy,
    input  logic              seq_wr,
    input  logic              seq_done,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              launch,
    output logic              launch_wr,
    output logic [DATA_W-1:0] wbuf,
    output logic              addr_load,
    output logic              addr_inc,
    output logic              resp_valid,
    output logic              resp_retry,
    output logic [DATA_W-1:0] resp_rdata
);

    logic valid_q, wr_pend_q, launch_rd_q, launch_wr_q;
    logic busy_any, wr_active, rd_hit, rd_fetch, wr_accept, ld_accept, wr_fire;

    // Classify the request in this cycle.
    always_comb begin
        busy_any  = seq_busy || wr_pend_q || launch_rd_q || launch_wr_q;
        wr_active = wr_pend_q || launch_wr_q || (seq_busy && seq_wr);
        rd_hit    = host_rd && valid_q;
        rd_fetch  = host_rd && !valid_q && !busy_any;
        wr_accept = host_wr && !wr_active;
        ld_accept = host_addr_ld && !busy_any;
        wr_fire   = wr_pend_q && !seq_busy && !launch_rd_q && !launch_wr_q;
    end

    assign addr_load = ld_accept;
    assign addr_inc  = cfg_autoinc && (rd_hit || (seq_done && seq_wr));
    assign launch    = launch_rd_q || launch_wr_q;
    assign launch_wr = launch_wr_q;

    // Track the launches, the posted write and the held read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q     <= 1'b0;
            wr_pend_q   <= 1'b0;
            launch_rd_q <= 1'b0;
            launch_wr_q <= 1'b0;
            wbuf        <= '0;
        end else begin
            launch_rd_q <= rd_fetch;
            launch_wr_q <= wr_fire;
            if (wr_accept) begin
                wr_pend_q <= 1'b1;
                wbuf      <= host_wdata;
            end else if (wr_fire) begin
                wr_pend_q <= 1'b0;
            end
            if (wr_accept || ld_accept || (rd_hit && cfg_autoinc))
                valid_q <= 1'b0;
            else if (seq_done && !seq_wr && !wr_pend_q)
                valid_q <= 1'b1;
        end
    end

    // Register the one-cycle response to each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_retry <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= host_rd || host_wr || host_addr_ld;
            resp_retry <= (host_rd && !rd_hit) || (host_wr && !wr_accept)
                          || (host_addr_ld && !ld_accept);
            resp_rdata <= rd_hit ? rd_byte : '0;
        end
    end

endmodule

// File: rtl/flash_port_seq.sv
// Module: flash data port access sequencer (top).
// Single-byte host access to an external Flash/EPROM through a multiplexed bus.
// Reads are non-blocking and writes are posted.
// Assumes at most one host request per cycle, and config that changes only while idle.
module flash_port_seq #(
    parameter int DATA_W = 8,
    parameter int LO_W   = 8,
    parameter int WAIT_W = 4,
    localparam int ADDR_W = DATA_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_autoinc,
    input  logic              host_addr_ld,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              resp_valid,
    output logic              resp_retry,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [DATA_W-1:0] xd_out,
    output logic              xd_oe,
    input  logic [DATA_W-1:0] xd_in,
    output logic [LO_W-1:0]   xa_lo,
    output logic              xstrobe,
    output logic              xcs_n,
    output logic              xoe_n,
    output logic              xwe_n
);

    logic              launch, launch_wr, addr_load, addr_inc;
    logic              seq_busy, seq_wr, seq_done;
    logic [DATA_W-1:0] wbuf, rd_byte, addr_hi;

    fport_host #(.DATA_W(DATA_W)) host_i (
        .clk(clk), .rst_n(rst_n),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr_ld(host_addr_ld),
        .host_wdata(host_wdata), .cfg_autoinc(cfg_autoinc),
        .seq_busy(seq_busy), .seq_wr(seq_wr), .seq_done(seq_done), .rd_byte(rd_byte),
        .launch(launch), .launch_wr(launch_wr), .wbuf(wbuf),
        .addr_load(addr_load), .addr_inc(addr_inc),
        .resp_valid(resp_valid), .resp_retry(resp_retry), .resp_rdata(resp_rdata)
    );

    fport_addr #(.HI_W(DATA_W), .LO_W(LO_W)) addr_i (
        .clk(clk), .rst_n(rst_n),
        .load(addr_load), .load_val(host_addr), .inc(addr_inc),
        .addr_hi(addr_hi), .addr_lo(xa_lo)
    );

    fport_seq #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(launch), .start_wr(launch_wr), .wait_cnt(cfg_wait),
        .addr_hi(addr_hi), .wr_data(wbuf), .xd_in(xd_in),
        .busy(seq_busy), .op_wr(seq_wr), .done(seq_done), .rd_byte(rd_byte),
        .xd_out(xd_out), .xd_oe(xd_oe), .xstrobe(xstrobe),
        .xcs_n(xcs_n), .xoe_n(xoe_n), .xwe_n(xwe_n)
    );

endmodule

// File: rtl/flash_port_seq_checker.sv
// Module: protocol checker for flash_port_seq, attached with bind.
// Covers the port-level rules of the external bus and of the host handshake.
// Assumes that the host raises at most one request line per cycle.
module flash_port_seq_checker #(
    parameter int DATA_W = 8,
    parameter int LO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_rd,
    input logic              host_wr,
    input logic              host_addr_ld,
    input logic              resp_valid,
    input logic              resp_retry,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              xd_oe,
    input logic [LO_W-1:0]   xa_lo,
    input logic              xstrobe,
    input logic              xcs_n,
    input logic              xoe_n,
    input logic              xwe_n
);

    // Input rule for the host: one request at a time (R12).
    assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_rd, host_wr, host_addr_ld}));

    // A response follows every request, and nothing else (R12).
    assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd || host_wr || host_addr_ld) |=> resp_valid);
    assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd || host_wr || host_addr_ld) |=> !resp_valid);

    // The strobe lasts one cycle, drives the lines, and leads into chip-select (R2).
    assert_strobe_then_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xstrobe |=> (!xstrobe && !xcs_n));
    assert_strobe_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xstrobe |-> (xd_oe && xcs_n));
    assert_lo_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xcs_n && $past(!xcs_n)) |-> $stable(xa_lo));

    // Output-enable only inside chip-select, never together with write-enable (R3).
    assert_oe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !xoe_n |-> (!xcs_n && xwe_n && !xd_oe));

    // Write-enable only inside chip-select, with the data lines driven (R5).
    assert_we_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xwe_n |-> (!xcs_n && xd_oe && xoe_n));

    // A retry carries no data (R4).
    assert_retry_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_retry) |-> (resp_rdata == '0));

endmodule

bind flash_port_seq flash_port_seq_checker #(.DATA_W(DATA_W), .LO_W(LO_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr_ld(host_addr_ld),
    .resp_valid(resp_valid), .resp_retry(resp_retry), .resp_rdata(resp_rdata),
    .xd_oe(xd_oe), .xa_lo(xa_lo), .xstrobe(xstrobe),
    .xcs_n(xcs_n), .xoe_n(xoe_n), .xwe_n(xwe_n)
);

// File: tb/flash_port_seq_tb_top.sv
// Directed bench for flash_port_seq. It has a behavioural Flash model and a bus monitor.
module flash_port_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_wait = 4'd0;
    logic        cfg_autoinc = 1'b0;
    logic        host_addr_ld = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        resp_valid, resp_retry;
    logic [7:0]  resp_rdata, xd_out, xd_in, xa_lo;
    logic        xd_oe, xstrobe, xcs_n, xoe_n, xwe_n;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_port_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_autoinc(cfg_autoinc),
        .host_addr_ld(host_addr_ld), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .resp_valid(resp_valid), .resp_retry(resp_retry), .resp_rdata(resp_rdata),
        .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in), .xa_lo(xa_lo),
        .xstrobe(xstrobe), .xcs_n(xcs_n), .xoe_n(xoe_n), .xwe_n(xwe_n)
    );

    function automatic logic [7:0] fdata(input logic [7:0] hi, input logic [7:0] lo);
        return lo ^ {hi[3:0], hi[7:4]} ^ 8'h5A;
    endfunction

    // Flash model: an external latch for the upper byte; data only while output-enable is low.
    logic [7:0] ext_hi = '0;
    always @(posedge clk) if (xstrobe) ext_hi <= xd_out;
    assign xd_in = (!xcs_n && !xoe_n) ? fdata(ext_hi, xa_lo) : 8'h00;

    // Bus monitor: records the shape of each finished chip-select window.
    int         run = 0, we_run = 0, last_len = 0, last_we_len = 0, ops = 0;
    bit         oe_seen = 0, last_oe = 0, last_wr = 0;
    logic [7:0] cur_lo = '0, last_lo = '0, last_hi = '0, cur_wd = '0, last_wd = '0;
    always @(posedge clk) begin
        if (!xcs_n) begin
            run    <= run + 1;
            cur_lo <= xa_lo;
            if (!xoe_n) oe_seen <= 1'b1;
            if (!xwe_n) begin we_run <= we_run + 1; cur_wd <= xd_out; end
        end else if (run != 0) begin
            last_len    <= run;
            last_we_len <= we_run;
            last_oe     <= oe_seen;
            last_wr     <= (we_run != 0);
            last_lo     <= cur_lo;
            last_hi     <= ext_hi;
            last_wd     <= cur_wd;
            ops         <= ops + 1;
            run <= 0; we_run <= 0; oe_seen <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One host request: kind 0 read, 1 write, 2 address load. Checks the response pulse (R12).
    task automatic host_op(input int kind, input logic [15:0] val,
                           output bit retry, output logic [7:0] data);
        @(negedge clk);
        host_rd      = (kind == 0);
        host_wr      = (kind == 1);
        host_addr_ld = (kind == 2);
        host_wdata   = val[7:0];
        host_addr    = val;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0; host_addr_ld = 1'b0;
        chk(resp_valid == 1'b1, "R12", "response pulse", resp_valid, 1);
        retry = resp_retry;
        data  = resp_rdata;
    endtask

    task automatic wait_bus();
        repeat (int'(cfg_wait) + 8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk({xcs_n, xoe_n, xwe_n} == 3'b111, "R1", "strobes idle", {xcs_n, xoe_n, xwe_n}, 3'b111);
        chk({xstrobe, xd_oe, resp_valid} == 3'b000, "R1", "no activity", {xstrobe, xd_oe, resp_valid}, 0);
    endtask

    task automatic t_read(input logic [3:0] w, input logic [7:0] hi, input logic [7:0] lo);
        bit r; logic [7:0] d;
        cfg_wait = w;
        host_op(2, {hi, lo}, r, d);
        chk(r == 0, "R10", "idle load accepted", r, 0);
        host_op(0, 0, r, d);
        chk(r == 1 && d == 0, "R4", "first read retry", {r, d}, 9'h100);
        host_op(0, 0, r, d);
        chk(r == 1, "R4", "read during fetch retry", r, 1);
        wait_bus();
        chk(last_len == int'(w) + 1, "R3", "read cs width", last_len, int'(w) + 1);
        chk(last_oe == 1 && last_we_len == 0, "R3", "oe only", {last_oe, last_we_len[0]}, 2'b10);
        chk(last_hi == hi && last_lo == lo, "R2", "address phase", {last_hi, last_lo}, {hi, lo});
        host_op(0, 0, r, d);
        chk(r == 0 && d == fdata(hi, lo), "R4", "read returns byte", {r, d}, {1'b0, fdata(hi, lo)});
    endtask

    task automatic t_write(input logic [3:0] w);
        bit r; logic [7:0] d; int ops0; int exp_len;
        exp_len = (w == 0) ? 1 : int'(w);
        cfg_wait = w;
        host_op(2, 16'h1357, r, d);
        ops0 = ops;
        host_op(1, 16'h00A5, r, d);
        chk(r == 0, "R6", "posted write no retry", r, 0);
        host_op(1, 16'h003C, r, d);
        chk(r == 1, "R6", "colliding write retry", r, 1);
        wait_bus();
        chk(ops == ops0 + 1, "R6", "dropped write makes no cycle", ops, ops0 + 1);
        chk(last_len == exp_len && last_we_len == exp_len, "R5", "write widths",
            {last_len[7:0], last_we_len[7:0]}, {exp_len[7:0], exp_len[7:0]});
        chk(last_oe == 0 && last_wd == 8'hA5, "R5", "oe high and data", {last_oe, last_wd}, 9'h0A5);
    endtask

    task automatic t_autoinc();
        bit r; logic [7:0] d; int ops0;
        cfg_wait = 4'd2; cfg_autoinc = 1'b1;
        host_op(2, 16'h56FE, r, d);
        host_op(0, 0, r, d); wait_bus();
        host_op(0, 0, r, d);
        chk(r == 0 && d == fdata(8'h56, 8'hFE), "R7", "read at FE", d, fdata(8'h56, 8'hFE));
        host_op(0, 0, r, d);
        chk(r == 1, "R7", "next read refetches", r, 1);
        wait_bus();
        chk(last_lo == 8'hFF, "R7", "low byte stepped", last_lo, 8'hFF);
        host_op(0, 0, r, d);
        host_op(0, 0, r, d); wait_bus();
        chk(last_lo == 8'h00 && last_hi == 8'h56, "R8", "wrap without carry", {last_hi, last_lo}, 16'h5600);
        host_op(0, 0, r, d);
        chk(d == fdata(8'h56, 8'h00), "R8", "byte after wrap", d, fdata(8'h56, 8'h00));
        host_op(1, 16'h0077, r, d); wait_bus();
        chk(last_lo == 8'h01, "R7", "write at stepped address", last_lo, 8'h01);
        host_op(0, 0, r, d); wait_bus();
        chk(last_lo == 8'h02, "R7", "step after write", last_lo, 8'h02);
        host_op(0, 0, r, d);
        cfg_autoinc = 1'b0;
        host_op(2, 16'h2040, r, d);
        host_op(0, 0, r, d); wait_bus();
        host_op(0, 0, r, d);
        ops0 = ops;
        host_op(0, 0, r, d);
        wait_bus();
        chk(r == 0 && d == fdata(8'h20, 8'h40) && ops == ops0, "R7", "no step when off", {r, d}, {1'b0, fdata(8'h20, 8'h40)});
    endtask

    task automatic t_invalidate();
        bit r; logic [7:0] d;
        host_op(2, 16'h2040, r, d);
        host_op(0, 0, r, d);
        chk(r == 1, "R9", "retry after address load", r, 1);
        wait_bus();
        host_op(0, 0, r, d);
        chk(r == 0, "R9", "refetched", r, 0);
        host_op(1, 16'h0011, r, d); wait_bus();
        host_op(0, 0, r, d);
        chk(r == 1, "R9", "retry after write", r, 1);
        wait_bus();
    endtask

    task automatic t_load_busy();
        bit r; logic [7:0] d;
        cfg_wait = 4'd4;
        host_op(2, 16'h3311, r, d);
        host_op(0, 0, r, d);
        host_op(2, 16'h7777, r, d);
        chk(r == 1, "R10", "load while busy retry", r, 1);
        wait_bus();
        host_op(0, 0, r, d);
        chk(r == 0 && d == fdata(8'h33, 8'h11), "R10", "address unchanged", d, fdata(8'h33, 8'h11));
    endtask

    task automatic t_write_in_read();
        bit r; logic [7:0] d; int ops0;
        cfg_wait = 4'd6;
        host_op(2, 16'h4422, r, d);
        ops0 = ops;
        host_op(0, 0, r, d);
        host_op(1, 16'h0099, r, d);
        chk(r == 0, "R11", "write accepted during fetch", r, 0);
        wait_bus(); wait_bus();
        chk(ops == ops0 + 2 && last_wr == 1, "R11", "write after read", {ops[7:0], 7'd0, last_wr}, {ops0[7:0] + 8'd2, 8'd1});
        chk(last_wd == 8'h99 && last_lo == 8'h22, "R11", "write data", {last_wd, last_lo}, 16'h9922);
        host_op(0, 0, r, d);
        chk(r == 1, "R11", "fetched byte discarded", r, 1);
        wait_bus();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_read(4'd3, 8'h12, 8'h34);
        t_read(4'd0, 8'hA0, 8'h0F);
        t_read(4'd15, 8'h3C, 8'hC3);
        t_write(4'd5);
        t_write(4'd0);
        t_autoinc();
        t_invalidate();
        t_load_busy();
        t_write_in_read();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule